// File: doc/BRIEF.md
# Address Table Scan Engine

This block lets a host read out every valid entry of a forwarding address table without knowing how entries are placed. The host sets the go bit in the control word. The engine then reads the table in ascending index order, one entry per clock, through a read port that returns data one cycle after the request. Entries whose valid flag is clear are skipped. Each valid entry is copied into one of two result slots. A slot holds a 64-bit word with the MAC address and VLAN ID and a 32-bit forwarding word.

When both slots are full, the engine raises a ready flag and stops reading. It waits until the host has collected the pair. Reading the forwarding word of the second slot counts as the acknowledge. That read clears the slots and lets the scan continue from the entry after the last one reported.

When the table is exhausted, any pair that is only half full is offered with an all-zero second slot. The go bit then drops. If nothing is left to offer, the go bit drops with both slots at zero, and the host reads this as end of data. Filtering the results by port or VLAN is left to the host.

Top module: `addr_scan_engine`

## Requirements
- R1: After reset, every host word (0 to 7) reads zero and no table read is issued.
- R2: A host write to word 0 with bit 7 set, while the engine is idle, starts a scan whose first table read is index 0. Bit 7 of word 0 reads 1 from the cycle after that write until the scan ends.
- R3: Bit 6 of word 0 holds the last value written to it and reads back unchanged. A write to word 0 with bit 7 clear starts no scan.
- R4: Only entries with bit 16 of the forwarding word set are reported. Each is reported exactly once, in ascending index order, and slot 0 is filled before slot 1. Slot 1 never holds a valid entry while slot 0 does not.
- R5: When both slots hold a valid entry, bit 0 of word 0 (ready) is set. From then until the acknowledge, no table read is issued and the slot contents do not change.
- R6: A read of word 6 while ready is set is the acknowledge. From the next cycle, ready reads 0, all slot words read 0, and the scan resumes.
- R7: If the table ends with one entry captured, that entry is offered with slot 1 all zero and ready set. The acknowledge of that pair clears bit 7 of word 0.
- R8: If the table ends with no entry captured, bit 7 clears with ready at 0 and both slots at zero. On a table with no valid entry, this happens no later than DEPTH+2 clock edges after the start write.
- R9: Writes to word 0 during a scan neither restart nor stop it, and they change neither ready nor the slot contents.
- R10: Host word map: 0 control {bit 7 go/busy, bit 6 VLAN-mode select, bit 0 ready}; 1, 2, 3 are slot 0 MAC/VID bits 31:0, MAC/VID bits 63:32, forwarding word; 4, 5, 6 are the same for slot 1; 7 reads zero.
- R11: Table reads go to consecutive indices on consecutive cycles, and read data is taken one cycle after the request. On a fully valid table, ready is set 3 clock edges after the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (matters only for word 6) |
| host_addr | input | 3 | Host word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr, combinational |
| tbl_rd_en | output | 1 | Table read request |
| tbl_rd_addr | output | AW | Table index to read |
| tbl_rd_macvid | input | 64 | MAC/VID word returned one cycle after the request |
| tbl_rd_fwd | input | 32 | Forwarding word returned one cycle after the request |

## Verification
The bench builds the engine with DEPTH set to 64, so a full pass over the table takes under a hundred cycles. At that size many complete scans fit in one run: an empty table, a fully valid table, a lone entry at the last index, entries only at the two ends, and several random densities. These cases reach even and odd result counts, pairs cut off at the end of the table, and a pause while the host delays its acknowledge. The shortest path from start to the first pair and the upper bound on an empty scan are both measured in clock edges at this depth.

// File: rtl/ase_pkg.sv
package ase_pkg;
    localparam int MACVID_W  = 64;
    localparam int FWD_W     = 32;
    localparam int HREG_W    = 32;
    localparam int NSLOT     = 2;
    localparam int SEL_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    localparam int FWD_VALID = 16;
    localparam int CTRL_GO   = 7;
    localparam int CTRL_VSEL = 6;
    localparam int CTRL_RDY  = 0;

    typedef enum logic [2:0] {
        W_CTRL   = 3'd0,
        W_S0_LO  = 3'd1,
        W_S0_HI  = 3'd2,
        W_S0_FWD = 3'd3,
        W_S1_LO  = 3'd4,
        W_S1_HI  = 3'd5,
        W_S1_FWD = 3'd6,
        W_RSVD   = 3'd7
    } word_e;

    typedef struct packed {
        logic [MACVID_W-1:0] macvid;
        logic [FWD_W-1:0]    fwd;
    } entry_t;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_SCAN = 2'd1,
        SC_HOLD = 2'd2
    } scan_st_e;
endpackage

// File: rtl/ase_result_slots.sv
module ase_result_slots
    import ase_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         cap_en,
    input  logic [SEL_W-1:0]             cap_sel,
    input  entry_t                       din,
    output entry_t [NSLOT-1:0]           slots
);
    entry_t [NSLOT-1:0] slots_d, slots_q;

    always_comb begin
        slots_d = slots_q;
        for (int i = 0; i < NSLOT; i++) begin
            if (clr) begin
                slots_d[i] = '0;
            end else if (cap_en && (cap_sel == SEL_W'(i))) begin
                slots_d[i] = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slots_q <= '0;
        else        slots_q <= slots_d;
    end

    assign slots = slots_q;
endmodule

// File: rtl/ase_scan_ctrl.sv
module ase_scan_ctrl
    import ase_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             ack,
    input  logic             rsp_valid_bit,
    output logic             tbl_rd_en,
    output logic [AW-1:0]    tbl_rd_addr,
    output logic             busy,
    output logic             rdy,
    output logic             cap_en,
    output logic [SEL_W-1:0] cap_sel,
    output logic             clr
);
    localparam logic [AW:0]      DEPTH_W  = (AW+1)'(DEPTH);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NSLOT-1);

    typedef struct packed {
        scan_st_e         st;
        logic [AW:0]      ptr;
        logic             pend;
        logic [AW-1:0]    pidx;
        logic [SEL_W-1:0] fill;
        logic             fin;
        logic             rdy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic hit, more, last_slot;

    always_comb begin
        ctl_d     = ctl_q;
        clr       = 1'b0;
        cap_en    = 1'b0;
        tbl_rd_en = 1'b0;
        hit       = ctl_q.pend && rsp_valid_bit;
        more      = (ctl_q.ptr < DEPTH_W);
        last_slot = (ctl_q.fill == LAST_SEL);
        unique case (ctl_q.st)
            SC_IDLE: begin
                if (start_req) begin
                    ctl_d.st   = SC_SCAN;
                    ctl_d.ptr  = '0;
                    ctl_d.pend = 1'b0;
                    ctl_d.fill = '0;
                    ctl_d.fin  = 1'b0;
                    ctl_d.rdy  = 1'b0;
                    clr        = 1'b1;
                end
            end
            SC_SCAN: begin
                cap_en = hit;
                if (hit && last_slot) begin
                    ctl_d.st   = SC_HOLD;
                    ctl_d.rdy  = 1'b1;
                    ctl_d.pend = 1'b0;
                    ctl_d.fill = '0;
                    ctl_d.ptr  = (AW+1)'(ctl_q.pidx) + 1'b1;
                end else if (!more && !ctl_q.pend) begin
                    if (ctl_q.fill != '0) begin
                        ctl_d.st   = SC_HOLD;
                        ctl_d.rdy  = 1'b1;
                        ctl_d.fin  = 1'b1;
                        ctl_d.fill = '0;
                    end else begin
                        ctl_d.st = SC_IDLE;
                    end
                end else begin
                    tbl_rd_en  = more;
                    ctl_d.pend = more;
                    ctl_d.pidx = ctl_q.ptr[AW-1:0];
                    if (more) ctl_d.ptr  = ctl_q.ptr + 1'b1;
                    if (hit)  ctl_d.fill = ctl_q.fill + 1'b1;
                end
            end
            SC_HOLD: begin
                if (ack) begin
                    ctl_d.rdy = 1'b0;
                    ctl_d.fin = 1'b0;
                    ctl_d.st  = ctl_q.fin ? SC_IDLE : SC_SCAN;
                    clr       = 1'b1;
                end
            end
            default: ctl_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: SC_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign tbl_rd_addr = ctl_q.ptr[AW-1:0];
    assign busy        = (ctl_q.st != SC_IDLE);
    assign rdy         = ctl_q.rdy;
    assign cap_sel     = ctl_q.fill;
endmodule

// File: rtl/ase_host_regs.sv
module ase_host_regs
    import ase_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [2:0]         host_addr,
    input  logic [HREG_W-1:0]  host_wdata,
    input  logic               busy,
    input  logic               rdy,
    input  entry_t [NSLOT-1:0] slots,
    output logic [HREG_W-1:0]  host_rdata,
    output logic               start_req,
    output logic               ack
);
    typedef struct packed {
        logic vsel;
    } hreg_t;

    hreg_t hreg_d, hreg_q;
    word_e widx;

    always_comb begin
        widx      = word_e'(host_addr);
        hreg_d    = hreg_q;
        start_req = host_we && (widx == W_CTRL) && host_wdata[CTRL_GO] && !busy;
        ack       = host_re && (widx == W_S1_FWD) && rdy;
        if (host_we && (widx == W_CTRL)) hreg_d.vsel = host_wdata[CTRL_VSEL];

        host_rdata = '0;
        unique case (widx)
            W_CTRL: begin
                host_rdata[CTRL_GO]   = busy;
                host_rdata[CTRL_VSEL] = hreg_q.vsel;
                host_rdata[CTRL_RDY]  = rdy;
            end
            W_S0_LO:  host_rdata = slots[0].macvid[31:0];
            W_S0_HI:  host_rdata = slots[0].macvid[63:32];
            W_S0_FWD: host_rdata = slots[0].fwd;
            W_S1_LO:  host_rdata = slots[1].macvid[31:0];
            W_S1_HI:  host_rdata = slots[1].macvid[63:32];
            W_S1_FWD: host_rdata = slots[1].fwd;
            default:  host_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hreg_q <= '0;
        else        hreg_q <= hreg_d;
    end
endmodule

// File: rtl/addr_scan_engine.sv
module addr_scan_engine
    import ase_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              tbl_rd_en,
    output logic [AW-1:0]     tbl_rd_addr,
    input  logic [63:0]       tbl_rd_macvid,
    input  logic [31:0]       tbl_rd_fwd
);
    entry_t              rsp;
    entry_t [NSLOT-1:0]  slots;
    logic                start_req, ack, busy, rdy, cap_en, clr;
    logic [SEL_W-1:0]    cap_sel;

    assign rsp.macvid = tbl_rd_macvid;
    assign rsp.fwd    = tbl_rd_fwd;

    ase_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .busy       (busy),
        .rdy        (rdy),
        .slots      (slots),
        .host_rdata (host_rdata),
        .start_req  (start_req),
        .ack        (ack)
    );

    ase_scan_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_req     (start_req),
        .ack           (ack),
        .rsp_valid_bit (tbl_rd_fwd[FWD_VALID]),
        .tbl_rd_en     (tbl_rd_en),
        .tbl_rd_addr   (tbl_rd_addr),
        .busy          (busy),
        .rdy           (rdy),
        .cap_en        (cap_en),
        .cap_sel       (cap_sel),
        .clr           (clr)
    );

    ase_result_slots u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .cap_en  (cap_en),
        .cap_sel (cap_sel),
        .din     (rsp),
        .slots   (slots)
    );
endmodule

// File: rtl/ase_checker.sv
module ase_checker
    import ase_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_rd_en,
    input  logic [AW-1:0]      tbl_rd_addr,
    input  logic               busy,
    input  logic               rdy,
    input  logic               ack,
    input  entry_t [NSLOT-1:0] slots
);
    p_first_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tbl_rd_en && (tbl_rd_addr == '0)));

    p_slot_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slots[1].fwd[FWD_VALID] |-> slots[0].fwd[FWD_VALID]);

    p_no_read_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> !tbl_rd_en);

    p_slots_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !ack) |=> $stable(slots));

    p_ack_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!rdy && (slots == '0)));

    p_ready_in_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> busy);

    p_step_by_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_en && $past(tbl_rd_en)) |-> (tbl_rd_addr == AW'($past(tbl_rd_addr) + 1'b1)));
endmodule

bind addr_scan_engine ase_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tbl_rd_en   (tbl_rd_en),
    .tbl_rd_addr (tbl_rd_addr),
    .busy        (busy),
    .rdy         (rdy),
    .ack         (ack),
    .slots       (slots)
);

// File: tb/addr_scan_engine_bench.sv
`timescale 1ns/1ps
module addr_scan_engine_bench;
    localparam int BD = 64;
    localparam int BAW = $clog2(BD);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_we = 1'b0, h_re = 1'b0;
    logic [2:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic t_en;
    logic [BAW-1:0] t_addr;
    logic [63:0] t_mv;
    logic [31:0] t_fw;

    logic [63:0] tm_mv [BD];
    logic [31:0] tm_fw [BD];
    logic [63:0] got_mv [BD];
    logic [31:0] got_fw [BD];
    int got_n;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    addr_scan_engine #(.DEPTH(BD)) u_addr_scan_engine (
        .clk(clk), .rst_n(rst_n),
        .host_we(h_we), .host_re(h_re), .host_addr(h_addr),
        .host_wdata(h_wdata), .host_rdata(h_rdata),
        .tbl_rd_en(t_en), .tbl_rd_addr(t_addr),
        .tbl_rd_macvid(t_mv), .tbl_rd_fwd(t_fw)
    );

    always_ff @(posedge clk) begin
        if (t_en) begin
            t_mv <= tm_mv[t_addr];
            t_fw <= tm_fw[t_addr];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        h_addr = a;
        #0.1;
        d = h_rdata;
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
        h_addr = a; h_wdata = d; h_we = 1'b1;
        @(posedge clk);
        #2;
        h_we = 1'b0;
    endtask

    task automatic hack();
        h_addr = 3'd6; h_re = 1'b1;
        @(posedge clk);
        #2;
        h_re = 1'b0;
    endtask

    // mode: 0 random(pct), 1 empty, 2 full, 3 last only, 4 both ends
    task automatic fill_table(input int mode, input int pct);
        for (int i = 0; i < BD; i++) begin
            bit v;
            tm_mv[i] = {$urandom, $urandom};
            tm_fw[i] = $urandom;
            case (mode)
                0: v = (($urandom % 100) < pct);
                1: v = 0;
                2: v = 1;
                3: v = (i == BD-1);
                default: v = (i == 0) || (i == BD-1);
            endcase
            tm_fw[i][16] = v;
        end
    endtask

    task automatic run_scan(input int mode, input bit poke);
        int edges, exp_n;
        bit first, partial;
        logic [31:0] c, a0, a1, a2, b0, b1, b2, x;
        got_n = 0; edges = 0; first = 1; partial = 0;
        hwrite(3'd0, 32'h80);
        peek(3'd0, c);
        check(c[7] == 1'b1, "R2", "go bit after start", c, 32'h80);
        forever begin
            tick();
            edges++;
            if (edges > BD*8 + 200) begin
                check(0, "R8", "scan never ended", edges, BD);
                break;
            end
            peek(3'd0, c);
            if (c[0]) begin
                peek(3'd1, a0); peek(3'd2, a1); peek(3'd3, a2);
                peek(3'd4, b0); peek(3'd5, b1); peek(3'd6, b2);
                if (first && mode == 2) check(edges == 3, "R11", "edges to first pair", edges, 3);
                first = 0;
                check(a2[16] == 1'b1, "R4", "slot0 valid when ready", a2, 32'h10000);
                if (a2[16] && got_n < BD) begin got_mv[got_n] = {a1, a0}; got_fw[got_n] = a2; got_n++; end
                if (b2[16]) begin
                    if (got_n < BD) begin got_mv[got_n] = {b1, b0}; got_fw[got_n] = b2; got_n++; end
                end else begin
                    check({b1, b0} == 64'h0 && b2 == 32'h0, "R7", "short pair slot1 zero", {b1, b0}, 64'h0);
                    partial = 1;
                end
                begin
                    bit ok;
                    ok = 1;
                    for (int k = 0; k < 3; k++) begin
                        tick();
                        if (t_en) ok = 0;
                        peek(3'd3, x); if (x != a2) ok = 0;
                        peek(3'd6, x); if (x != b2) ok = 0;
                        peek(3'd0, x); if (!x[0]) ok = 0;
                    end
                    check(ok, "R5", "pause while ready", t_en, 0);
                end
                if (poke) begin
                    hwrite(3'd0, 32'hC0);
                    peek(3'd0, x);
                    check(x == 32'hC1, "R9", "ctrl after write while held", x, 32'hC1);
                    peek(3'd1, x);
                    check(x == a0, "R9", "slot0 kept after write", x, a0);
                    hwrite(3'd0, 32'h80);
                    peek(3'd0, x);
                    check(x[6] == 1'b0, "R3", "vlan select readback", x, 0);
                    poke = 0;
                end
                hack();
                peek(3'd0, x);
                check(x[0] == 1'b0, "R6", "ready after ack", x, 0);
                peek(3'd6, c);
                peek(3'd1, a0);
                check(c == 0 && a0 == 0, "R6", "slots cleared by ack", {c, a0}, 0);
                if (partial) begin
                    check(x[7] == 1'b0, "R7", "go clears after short pair", x, 0);
                    break;
                end
            end else if (!c[7]) begin
                peek(3'd3, a2); peek(3'd6, b2); peek(3'd1, a0); peek(3'd4, b0);
                check(a2 == 0 && b2 == 0 && a0 == 0 && b0 == 0, "R8", "slots zero at end",
                      {a2, b2}, 0);
                if (mode == 1) check(edges <= BD + 2, "R8", "empty scan length", edges, BD + 2);
                break;
            end
        end
        exp_n = 0;
        for (int i = 0; i < BD; i++) begin
            if (tm_fw[i][16]) begin
                if (exp_n < got_n)
                    check(got_mv[exp_n] == tm_mv[i] && got_fw[exp_n] == tm_fw[i], "R4",
                          "entry content/order", got_mv[exp_n], tm_mv[i]);
                exp_n++;
            end
        end
        check(got_n == exp_n, "R4", "reported count", got_n, exp_n);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        fill_table(1, 0);
        repeat (3) @(posedge clk);
        #2;
        check(t_en == 1'b0, "R1", "no read in reset", t_en, 0);
        rst_n = 1'b1;
        tick();
        for (int w = 0; w < 8; w++) begin
            peek(w[2:0], d);
            check(d == 32'h0, (w == 7) ? "R10" : "R1", "word after reset", d, 0);
        end
        check(t_en == 1'b0, "R1", "no read after reset", t_en, 0);

        hwrite(3'd0, 32'h40);
        peek(3'd0, d);
        check(d == 32'h40, "R3", "vlan select set, no start", d, 32'h40);
        begin
            bit ok;
            ok = 1;
            for (int k = 0; k < 4; k++) begin tick(); if (t_en) ok = 0; end
            check(ok, "R3", "no scan from bit6-only write", t_en, 0);
        end
        hwrite(3'd0, 32'h00);
        peek(3'd0, d);
        check(d == 32'h0, "R3", "vlan select cleared", d, 0);

        fill_table(1, 0);  run_scan(1, 0);
        fill_table(2, 0);  run_scan(2, 0);
        fill_table(3, 0);  run_scan(3, 0);
        fill_table(4, 0);  run_scan(4, 0);
        fill_table(0, 50); run_scan(0, 1);
        fill_table(0, 20); run_scan(0, 0);
        fill_table(0, 85); run_scan(0, 0);
        for (int r = 0; r < 4; r++) begin
            fill_table(0, 5 + 30 * r);
            run_scan(0, 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule